// File: doc/BRIEF.md
# Floating-Point NaN Quieting Unit

This purely combinational block looks at one binary floating-point operand (single precision by default) and says whether it encodes a NaN and, if so, whether that NaN is signaling. When the operand is a signaling NaN, the block also produces its quiet counterpart and raises an invalid-operation flag. Every other operand passes through unchanged with the flag low. The unit sits at the front of an arithmetic pipeline, in front of the stage that forwards NaN operands to the result.

A single mode pin selects which polarity of the most significant fraction bit marks a quiet NaN. In the legacy polarity a set top bit means signaling. In the 2008 polarity a set top bit means quiet. Quieting in legacy polarity clears the top bit. If that leaves the fraction empty, the operand would turn into an infinity, so the unit sets the next-lower fraction bit to keep the value a NaN.

There is no data stream here and no handshake. Every pin is plain, and the outputs follow the inputs within the same cycle.

Top module: `fpq_nan_quiet`

## Requirements
- R1: `is_nan` is 1 exactly when the exponent field (bits [30:23] by default) is all ones and the fraction field (bits [22:0]) is nonzero.
- R2: `is_snan` is 1 exactly when `is_nan` is 1 and the top fraction bit (bit 22) XOR `nan2008` equals 1, where `nan2008`=1 selects the 2008 polarity and 0 the legacy polarity.
- R3: When the operand is not a signaling NaN, `quiet_out` equals `op_in` and `invalid` is 0.
- R4: `invalid` is 1 whenever the operand is a signaling NaN.
- R5: With `nan2008`=1, a signaling NaN is quieted by setting bit 22 and leaving every other bit unchanged.
- R6: With `nan2008`=0, a signaling NaN is quieted by clearing bit 22. All other bits stay unchanged whenever bits [21:0] are not all zero.
- R7: With `nan2008`=0, when clearing bit 22 leaves a zero fraction, bit 21 is set in the result.
- R8: The sign bit and exponent field of `quiet_out` always equal those of `op_in`.
- R9: For a signaling NaN input, `quiet_out` is a NaN whose top fraction bit equals `nan2008`, so it is a quiet NaN under the same mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_in | input | 32 | Operand: sign, exponent field, fraction field |
| nan2008 | input | 1 | 1: a set top fraction bit marks a quiet NaN; 0: legacy polarity |
| is_nan | output | 1 | Operand is a NaN |
| is_snan | output | 1 | Operand is a signaling NaN under the current mode |
| quiet_out | output | 32 | Quieted operand, or the operand unchanged |
| invalid | output | 1 | Invalid-operation flag, raised when a signaling NaN is quieted |

## Verification
The bench builds two instances. One uses the default 8-bit exponent and 23-bit fraction. There, directed single-precision patterns go through a scoreboard: infinities, zeros, a near-NaN exponent, payload extremes, and the legacy case whose payload is only the top bit. The second instance uses a 3-bit exponent and a 3-bit fraction. That format is small enough to sweep every encoding under both polarities. So every combination of sign, exponent and fraction, including each legacy empty-fraction case, gets compared against an independent model.

// File: rtl/fpq_pkg.sv
package fpq_pkg;
  // Polarity of the top fraction bit for quiet NaNs.
  typedef enum logic {
    NAN_POL_LEGACY = 1'b0,
    NAN_POL_2008   = 1'b1
  } nan_pol_e;
endpackage

// File: rtl/fpq_classify.sv
module fpq_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WIDTH = EXP_W + FRAC_W + 1
) (
  input  logic [WIDTH-1:0] op,
  input  fpq_pkg::nan_pol_e pol,
  output logic             nan,
  output logic             snan
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_full;
  logic              frac_nz;

  assign exp_f    = op[WIDTH-2 -: EXP_W];
  assign frac_f   = op[FRAC_W-1:0];
  assign exp_full = &exp_f;
  assign frac_nz  = |frac_f;
  assign nan      = exp_full & frac_nz;
  // Signaling when the top fraction bit disagrees with the quiet polarity.
  assign snan     = nan & (frac_f[FRAC_W-1] ^ (pol == fpq_pkg::NAN_POL_2008));
endmodule

// File: rtl/fpq_quieter.sv
module fpq_quieter #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WIDTH = EXP_W + FRAC_W + 1
) (
  input  logic [WIDTH-1:0] op,
  input  fpq_pkg::nan_pol_e pol,
  output logic [WIDTH-1:0] quieted
);
  localparam int TOP = FRAC_W - 1;

  logic [FRAC_W-1:0] frac_in;
  logic [FRAC_W-1:0] frac_q;

  assign frac_in = op[FRAC_W-1:0];

  generate
    if (FRAC_W >= 2) begin : g_guard
      // Legacy quieting may empty the fraction; refill the next bit.
      logic rest_zero;
      assign rest_zero = ~|frac_in[TOP-1:0];
      always_comb begin
        frac_q = frac_in;
        if (pol == fpq_pkg::NAN_POL_2008) begin
          frac_q[TOP] = 1'b1;
        end else begin
          frac_q[TOP] = 1'b0;
          if (rest_zero) frac_q[TOP-1] = 1'b1;
        end
      end
    end else begin : g_one
      // Single fraction bit: only the 2008 polarity is meaningful.
      always_comb begin
        frac_q = frac_in;
        frac_q[TOP] = 1'b1;
      end
    end
  endgenerate

  assign quieted = {op[WIDTH-1:FRAC_W], frac_q};
endmodule

// File: rtl/fpq_nan_quiet.sv
module fpq_nan_quiet #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WIDTH = EXP_W + FRAC_W + 1
) (
  input  logic [WIDTH-1:0] op_in,
  input  logic             nan2008,
  output logic             is_nan,
  output logic             is_snan,
  output logic [WIDTH-1:0] quiet_out,
  output logic             invalid
);
  fpq_pkg::nan_pol_e pol;
  logic [WIDTH-1:0]  q_val;

  assign pol = fpq_pkg::nan_pol_e'(nan2008);

  fpq_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .op   (op_in),
    .pol  (pol),
    .nan  (is_nan),
    .snan (is_snan)
  );

  fpq_quieter #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_qt (
    .op      (op_in),
    .pol     (pol),
    .quieted (q_val)
  );

  assign quiet_out = is_snan ? q_val : op_in;
  assign invalid   = is_snan;
endmodule

// File: rtl/fpq_nan_quiet_chk.sv
module fpq_nan_quiet_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WIDTH = EXP_W + FRAC_W + 1
) (
  input logic [WIDTH-1:0] op_in,
  input logic             nan2008,
  input logic             is_nan,
  input logic             is_snan,
  input logic [WIDTH-1:0] quiet_out,
  input logic             invalid
);
  always_comb begin
    assert_snan_is_nan_R2: assert (!is_snan || is_nan)
      else $error("signaling without NaN");
    assert_passthru_R3: assert (is_snan || (quiet_out == op_in && !invalid))
      else $error("non-signaling operand altered");
    assert_flag_R4: assert (invalid == is_snan)
      else $error("invalid flag mismatch");
    assert_sign_exp_R8: assert (quiet_out[WIDTH-1:FRAC_W] == op_in[WIDTH-1:FRAC_W])
      else $error("sign or exponent changed");
    assert_result_quiet_R9: assert (!is_snan ||
        ((&quiet_out[WIDTH-2:FRAC_W]) && (|quiet_out[FRAC_W-1:0]) &&
         quiet_out[FRAC_W-1] == nan2008))
      else $error("quieted value not quiet");
    assert_set_top_R5: assert (!(is_snan && nan2008) ||
        quiet_out == (op_in | (WIDTH'(1) << (FRAC_W-1))))
      else $error("2008 quieting wrong");
  end
endmodule

bind fpq_nan_quiet fpq_nan_quiet_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .op_in     (op_in),
  .nan2008   (nan2008),
  .is_nan    (is_nan),
  .is_snan   (is_snan),
  .quiet_out (quiet_out),
  .invalid   (invalid)
);

// File: tb/sim_fpq_nan_quiet.sv
module sim_fpq_nan_quiet;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;

  // Default-format instance
  logic [31:0] op_a;
  logic        mode_a;
  logic        nan_a, snan_a, inv_a;
  logic [31:0] res_a;

  fpq_nan_quiet u0 (
    .op_in(op_a), .nan2008(mode_a), .is_nan(nan_a), .is_snan(snan_a),
    .quiet_out(res_a), .invalid(inv_a)
  );

  // Small-format instance: 3-bit exponent, 3-bit fraction
  logic [6:0] op_b;
  logic       mode_b;
  logic       nan_b, snan_b, inv_b;
  logic [6:0] res_b;

  fpq_nan_quiet #(.EXP_W(3), .FRAC_W(3)) u1 (
    .op_in(op_b), .nan2008(mode_b), .is_nan(nan_b), .is_snan(snan_b),
    .quiet_out(res_b), .invalid(inv_b)
  );

  typedef struct packed {
    logic [31:0] res;
    logic        nan;
    logic        snan;
    logic        inv;
  } exp_t;

  exp_t sb_q[$];
  string tag_q[$];

  // Independent model from the requirements
  function automatic exp_t model(logic [31:0] x, int ew, int fw, logic m);
    exp_t e;
    logic [31:0] fmask, emask, frac, ex, top;
    fmask = (32'd1 << fw) - 32'd1;
    emask = (32'd1 << ew) - 32'd1;
    frac  = x & fmask;
    ex    = (x >> fw) & emask;
    top   = 32'd1 << (fw - 1);
    e.nan  = (ex == emask) && (frac != 0);                  // R1
    e.snan = e.nan && (m ^ ((frac & top) != 0));             // R2
    e.inv  = e.snan;                                         // R4
    e.res  = x;                                              // R3
    if (e.snan) begin
      if (m) e.res = x | top;                                // R5
      else begin
        e.res = x & ~top;                                    // R6
        if ((e.res & fmask) == 0) e.res = e.res | (top >> 1); // R7
      end
    end
    return e;
  endfunction

  task automatic check(string tag, exp_t act, exp_t ex);
    n_run++;
    if (act !== ex) begin
      n_fail++;
      $display("FAIL %s: got res=%h nan=%b snan=%b inv=%b, expected res=%h nan=%b snan=%b inv=%b",
               tag, act.res, act.nan, act.snan, act.inv, ex.res, ex.nan, ex.snan, ex.inv);
    end
  endtask

  // Driver: applies the stimulus after a rising edge, queues the expectation
  task automatic drive(string tag, logic [31:0] x, logic m);
    @(posedge clk);
    op_a   = x;
    mode_a = m;
    sb_q.push_back(model(x, 8, 23, m));
    tag_q.push_back(tag);
  endtask

  // Monitor: compares on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t ex;
        string t;
        ex = sb_q.pop_front();
        t  = tag_q.pop_front();
        check(t, {res_a, nan_a, snan_a, inv_a}, ex);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    op_a = 32'h0; mode_a = 1'b0;
    op_b = 7'h0;  mode_b = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    drive("R3 zero at start", 32'h0000_0000, 1'b0);
    drive("R1 +inf not NaN", 32'h7F80_0000, 1'b0);
    drive("R1 -inf not NaN 2008", 32'hFF80_0000, 1'b1);
    drive("R1 exp FE not NaN", 32'h7F7F_FFFF, 1'b0);
    drive("R3 normal 1.0", 32'h3F80_0000, 1'b1);
    drive("R2 legacy quiet NaN", 32'h7F80_0001, 1'b0);
    drive("R2 2008 quiet NaN", 32'h7FC0_0000, 1'b1);
    drive("R5 2008 sNaN", 32'h7F80_0001, 1'b1);
    drive("R5 2008 sNaN neg payload", 32'hFFBF_FFFF, 1'b1);
    drive("R6 legacy sNaN payload kept", 32'h7FC0_1234, 1'b0);
    drive("R7 legacy top bit only", 32'h7FC0_0000, 1'b0);
    drive("R7 legacy top bit only neg", 32'hFFC0_0000, 1'b0);
    drive("R8 legacy sNaN full frac neg", 32'hFFFF_FFFF, 1'b0);
    drive("R4 legacy sNaN low bits", 32'h7FE0_0000, 1'b0);
    @(posedge clk);
    @(posedge clk);
    // Exhaustive sweep of the small format, both polarities
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 128; v++) begin
        exp_t ex;
        @(posedge clk);
        op_b   = 7'(v);
        mode_b = 1'(m);
        ex = model(32'(v), 3, 3, 1'(m));
        @(negedge clk);
        check("R1 R2 R3 R6 R7 R8 R9 small sweep",
              {25'd0, res_b, nan_b, snan_b, inv_b}, ex);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule